// File: doc/BRIEF.md
# Two-Port Mailbox With Ownership Handoff

This block is a 256-bit mailbox, eight 32-bit words, shared between a requester and a responder. The requester fills words 0 to 6 with request data over a word-addressed port. It then writes word 7, the header word, and that write also hands the mailbox to the responder. The responder reads the request over its own word-addressed port. It then writes a response header, and that write gives the mailbox back to the requester. Ownership is bit 31 of word 7 and is not kept in a separate register: 1 means the responder owns the mailbox, 0 means the requester owns it.

Word 7 carries the header fields used by software: message type in bits 2:0, version in bits 5:3, direction in bit 7 (0 request, 1 response), status in bits 15:8, reset-function flag in bit 24 and owner in bit 31. The block stores these fields unchanged and forces only bit 31. While the function-reset input is high, every read returns all ones. The stored contents are kept.

Both ports take a command every cycle and never push back. A read issued in one cycle returns its data with a valid strobe in the next cycle. A write takes effect at the clock edge on which it is issued. Only the current owner may write, so the two ports never write in the same cycle. A write from the side that does not own the mailbox is dropped, and that side's error output pulses for one cycle.

Top module: `mbox_handoff`

## Requirements
- R1: After reset every word reads 0, owner_rsp is 0, and both valid strobes and both error outputs are low.
- R2: A requester write to words 0 to 6 while owner_rsp is 0 stores the data, which a later read returns.
- R3: A requester write to word 7 while owner_rsp is 0 stores bits 30:0 as written and sets bit 31. owner_rsp is 1 from the following cycle.
- R4: A requester write to any word while owner_rsp is 1 leaves every word unchanged, and req_err is high for exactly the next cycle.
- R5: A responder write while owner_rsp is 1 stores the header into word 7 with bit 31 cleared. owner_rsp is 0 from the following cycle.
- R6: A responder write while owner_rsp is 0 leaves word 7 unchanged, and rsp_err is high for exactly the next cycle. If both ports write in the same cycle, the requester's write wins and the responder's write is dropped.
- R7: While fn_reset is high when a read is issued, that read returns 0xFFFFFFFF on either port. The stored words are unaffected.
- R8: Requester reads of words 0 to 6 return the stored data whichever side owns the mailbox.
- R9: The responder port reads any of the eight words, including the request header with bit 31 set.
- R10: Each read returns its data with the valid strobe exactly one cycle after it is issued. Reads on consecutive cycles are all served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_reset | input | 1 | Function in reset; reads return all ones |
| req_wr_en | input | 1 | Requester write strobe |
| req_rd_en | input | 1 | Requester read strobe |
| req_addr | input | 3 | Requester word index |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data |
| req_rd_valid | output | 1 | Requester read data valid |
| req_err | output | 1 | Pulse: requester write dropped |
| rsp_wr_en | input | 1 | Responder header write strobe (targets word 7) |
| rsp_wdata | input | 32 | Responder header; bit 31 is ignored |
| rsp_rd_en | input | 1 | Responder read strobe |
| rsp_addr | input | 3 | Responder word index |
| rsp_rdata | output | 32 | Responder read data |
| rsp_rd_valid | output | 1 | Responder read data valid |
| rsp_err | output | 1 | Pulse: responder write dropped |
| owner_rsp | output | 1 | Live copy of word 7 bit 31 |

## Verification
The hardest case to reach from the ports is the same-cycle collision, where both sides write while the requester owns the mailbox. The requester's write must win and the responder's write must be dropped. The bench drives both strobes on one edge and then reads word 7 through both ports to confirm who won. Reads made during function reset are the other hard case. The bench reads under fn_reset and then repeats the same reads with fn_reset low, which shows that the all-ones value masked the data and did not overwrite it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_WORD_W = 32;
  localparam int unsigned MBOX_WORDS  = 8;

  // Which side, if any, writes storage this cycle
  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_REQ  = 2'd1,
    GR_RSP  = 2'd2
  } mbox_grant_e;
endpackage

// File: rtl/mbox_arb.sv
module mbox_arb
  import mbox_pkg::*;
(
  input  logic        owner_rsp,
  input  logic        req_wr_en,
  input  logic        rsp_wr_en,
  output mbox_grant_e grant,
  output logic        req_drop,
  output logic        rsp_drop
);
  // The owner flag alone picks the writer; a same-cycle collision resolves by ownership
  always_comb begin
    grant    = GR_NONE;
    req_drop = 1'b0;
    rsp_drop = 1'b0;
    if (owner_rsp) begin
      req_drop = req_wr_en;
      if (rsp_wr_en) grant = GR_RSP;
    end else begin
      rsp_drop = rsp_wr_en;
      if (req_wr_en) grant = GR_REQ;
    end
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int unsigned WORD_W    = MBOX_WORD_W,
  parameter int unsigned NUM_WORDS = MBOX_WORDS
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  mbox_grant_e                          grant,
  input  logic [$clog2(NUM_WORDS)-1:0]         req_addr,
  input  logic [WORD_W-1:0]                    req_wdata,
  input  logic [WORD_W-1:0]                    rsp_wdata,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]     words
);
  localparam int unsigned AW   = $clog2(NUM_WORDS);
  localparam int unsigned LAST = NUM_WORDS - 1;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (g == LAST) begin : g_hdr
      // Header word: top bit is the owner flag, forced by whichever side writes
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          words[g] <= '0;
        else if (grant == GR_REQ && req_addr == AW'(g))
          words[g] <= {1'b1, req_wdata[WORD_W-2:0]};
        else if (grant == GR_RSP)
          words[g] <= {1'b0, rsp_wdata[WORD_W-2:0]};
      end
    end else begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          words[g] <= '0;
        else if (grant == GR_REQ && req_addr == AW'(g))
          words[g] <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fn_reset,
  input  logic                             rd_en,
  input  logic [$clog2(NUM_WORDS)-1:0]     addr,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]                rdata,
  output logic                             rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= fn_reset ? '1 : words[addr];
    end
  end
endmodule

// File: rtl/mbox_handoff.sv
module mbox_handoff
  import mbox_pkg::*;
#(
  parameter int unsigned WORD_W    = MBOX_WORD_W,
  parameter int unsigned NUM_WORDS = MBOX_WORDS,
  localparam int unsigned AW       = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fn_reset,
  input  logic              req_wr_en,
  input  logic              req_rd_en,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [WORD_W-1:0] req_rdata,
  output logic              req_rd_valid,
  output logic              req_err,
  input  logic              rsp_wr_en,
  input  logic [WORD_W-1:0] rsp_wdata,
  input  logic              rsp_rd_en,
  input  logic [AW-1:0]     rsp_addr,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_rd_valid,
  output logic              rsp_err,
  output logic              owner_rsp
);
  localparam int unsigned LAST = NUM_WORDS - 1;

  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  mbox_grant_e grant;
  logic req_drop, rsp_drop;

  assign owner_rsp = words[LAST][WORD_W-1];

  mbox_arb u_arb (
    .owner_rsp (owner_rsp),
    .req_wr_en (req_wr_en),
    .rsp_wr_en (rsp_wr_en),
    .grant     (grant),
    .req_drop  (req_drop),
    .rsp_drop  (rsp_drop)
  );

  mbox_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_wdata (rsp_wdata),
    .words     (words)
  );

  mbox_rdport #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_req_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fn_reset (fn_reset),
    .rd_en    (req_rd_en),
    .addr     (req_addr),
    .words    (words),
    .rdata    (req_rdata),
    .rd_valid (req_rd_valid)
  );

  mbox_rdport #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rsp_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fn_reset (fn_reset),
    .rd_en    (rsp_rd_en),
    .addr     (rsp_addr),
    .words    (words),
    .rdata    (rsp_rdata),
    .rd_valid (rsp_rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_err <= 1'b0;
      rsp_err <= 1'b0;
    end else begin
      req_err <= req_drop;
      rsp_err <= rsp_drop;
    end
  end
endmodule

// File: rtl/mbox_handoff_chk.sv
module mbox_handoff_chk #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned AW       = $clog2(NUM_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fn_reset,
  input logic              req_wr_en,
  input logic              req_rd_en,
  input logic [AW-1:0]     req_addr,
  input logic [WORD_W-1:0] req_wdata,
  input logic [WORD_W-1:0] req_rdata,
  input logic              req_rd_valid,
  input logic              req_err,
  input logic              rsp_wr_en,
  input logic [WORD_W-1:0] rsp_wdata,
  input logic              rsp_rd_en,
  input logic [AW-1:0]     rsp_addr,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              rsp_rd_valid,
  input logic              rsp_err,
  input logic              owner_rsp
);
  localparam logic [AW-1:0] HDR = AW'(NUM_WORDS - 1);

  p_owner_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr_en && req_addr == HDR && !owner_rsp) |=> owner_rsp);

  p_drop_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr_en && owner_rsp) |=> req_err);

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_wr_en && owner_rsp));

  p_owner_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wr_en && owner_rsp) |=> !owner_rsp);

  p_rsp_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wr_en && !owner_rsp) |=> rsp_err);

  p_owner_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_wr_en && !(req_wr_en && req_addr == HDR)) |=> $stable(owner_rsp));

  p_fnrst_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd_en && fn_reset) |=> (req_rd_valid && req_rdata == '1));

  p_fnrst_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rd_en && fn_reset) |=> (rsp_rd_valid && rsp_rdata == '1));

  p_rd_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd_en |=> req_rd_valid);

  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_rd_en |=> !rsp_rd_valid);
endmodule

bind mbox_handoff mbox_handoff_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (.*);

// File: tb/tb_mbox_handoff.sv
module tb_mbox_handoff;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fn_reset = 1'b0;
  logic        req_wr_en = 1'b0, req_rd_en = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rdata;
  logic        req_rd_valid, req_err;
  logic        rsp_wr_en = 1'b0, rsp_rd_en = 1'b0;
  logic [31:0] rsp_wdata = '0;
  logic [2:0]  rsp_addr = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_rd_valid, rsp_err, owner_rsp;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [8];
  logic        m_own = 1'b0;
  logic [31:0] req_q[$];
  logic [31:0] rsp_q[$];
  string       req_tag[$];
  string       rsp_tag[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mbox_handoff dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as valid strobes appear
  always @(negedge clk) begin
    if (rst_n && req_rd_valid) begin
      if (req_q.size() == 0) check("R10 req unexpected valid", 32'd1, 32'd0);
      else check(req_tag.pop_front(), req_rdata, req_q.pop_front());
    end
    if (rst_n && rsp_rd_valid) begin
      if (rsp_q.size() == 0) check("R10 rsp unexpected valid", 32'd1, 32'd0);
      else check(rsp_tag.pop_front(), rsp_rdata, rsp_q.pop_front());
    end
  end

  function automatic logic [31:0] exp_rd(input int a);
    return fn_reset ? 32'hFFFF_FFFF : model[a];
  endfunction

  task automatic req_read(input int a, input string tag);
    @(negedge clk);
    req_rd_en = 1'b1; req_addr = 3'(a);
    req_q.push_back(exp_rd(a)); req_tag.push_back(tag);
    @(negedge clk);
    req_rd_en = 1'b0;
  endtask

  task automatic rsp_read(input int a, input string tag);
    @(negedge clk);
    rsp_rd_en = 1'b1; rsp_addr = 3'(a);
    rsp_q.push_back(exp_rd(a)); rsp_tag.push_back(tag);
    @(negedge clk);
    rsp_rd_en = 1'b0;
  endtask

  // Drives one cycle with optional writes on both ports and checks the result
  task automatic write_cycle(input bit rq, input int a, input logic [31:0] d,
                             input bit rs, input logic [31:0] h, input string tag);
    bit e_req, e_rsp;
    @(negedge clk);
    req_wr_en = rq; req_addr = 3'(a); req_wdata = d;
    rsp_wr_en = rs; rsp_wdata = h;
    e_req = rq && m_own;
    e_rsp = rs && !m_own;
    if (!m_own && rq) begin
      model[a] = (a == 7) ? {1'b1, d[30:0]} : d;
      if (a == 7) m_own = 1'b1;
    end else if (m_own && rs) begin
      model[7] = {1'b0, h[30:0]};
      m_own = 1'b0;
    end
    @(negedge clk);
    req_wr_en = 1'b0; rsp_wr_en = 1'b0;
    check({tag, " req_err"}, {31'd0, req_err}, {31'd0, e_req});
    check({tag, " rsp_err"}, {31'd0, rsp_err}, {31'd0, e_rsp});
    check({tag, " owner"}, {31'd0, owner_rsp}, {31'd0, m_own});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 owner", {31'd0, owner_rsp}, 32'd0);
    check("R1 valid/err", {28'd0, req_rd_valid, rsp_rd_valid, req_err, rsp_err}, 32'd0);
    rst_n = 1'b1;
    req_read(3, "R1 word3");
    req_read(7, "R1 word7");

    // R2: fill request words
    for (int i = 0; i < 7; i++) write_cycle(1, i, 32'hA5A5_0000 ^ (i * 32'h0101_1111), 0, '0, "R2 wr");
    for (int i = 0; i < 7; i++) req_read(i, "R2 readback");

    // R3: header write hands over
    write_cycle(1, 7, 32'h0100_0001, 0, '0, "R3 hdr");
    req_read(7, "R3 hdr bit31");

    // R4: writes while responder owns are dropped
    write_cycle(1, 2, 32'hDEAD_BEEF, 0, '0, "R4 drop w2");
    write_cycle(1, 7, 32'h0000_0000, 0, '0, "R4 drop w7");
    req_read(2, "R4 word2 kept");
    req_read(7, "R4 word7 kept");

    // R8: requester reads under responder ownership
    req_read(5, "R8 word5");
    req_read(0, "R8 word0");

    // R9: responder reads the whole request
    for (int i = 0; i < 8; i++) rsp_read(i, "R9 rsp read");

    // R7: function reset masks reads, contents survive
    fn_reset = 1'b1;
    req_read(1, "R7 req all ones");
    rsp_read(7, "R7 rsp all ones");
    @(negedge clk);
    fn_reset = 1'b0;
    req_read(1, "R7 word1 kept");
    rsp_read(7, "R7 word7 kept");

    // R5: response header returns ownership, bit31 forced low
    write_cycle(0, 0, '0, 1, 32'h8000_0081, "R5 rsp hdr");
    req_read(7, "R5 hdr stored");

    // R6: responder write without ownership dropped
    write_cycle(0, 0, '0, 1, 32'h0000_0F81, "R6 drop");
    rsp_read(7, "R6 word7 kept");

    // R6: collision, requester owns and wins
    write_cycle(1, 7, 32'h0000_0002, 1, 32'h0000_0082, "R6 collide");
    req_read(7, "R6 collide req");
    rsp_read(7, "R6 collide rsp");

    // R10: back-to-back reads on both ports
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      req_rd_en = 1'b1; req_addr = 3'(i);
      rsp_rd_en = 1'b1; rsp_addr = 3'(7 - i);
      req_q.push_back(model[i]); req_tag.push_back("R10 burst req");
      rsp_q.push_back(model[7 - i]); rsp_tag.push_back("R10 burst rsp");
      @(negedge clk);
    end
    req_rd_en = 1'b0; rsp_rd_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 req queue drained", req_q.size(), 32'd0);
    check("R10 rsp queue drained", rsp_q.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule